// File: doc/BRIEF.md
# NAND Sector Hamming ECC Checker and Corrector

This block guards one 512-byte NAND sector with a single-error-correcting Hamming code. Bytes stream in after a sector-start strobe. While they pass, the block accumulates two 12-bit parity halves. The "odd" half takes, for each bit of the combined index {byte address, bit position}, the parity of the data bits whose index has that bit set. The "even" half takes the same parity over the bits whose index has that bit clear.

On the write path, the block stores nothing extra. Once the last byte of the sector is in, it emits the packed and inverted 24-bit code as three bytes, least significant byte first, ready to be written to the spare area.

On the read path, the three stored code bytes are loaded after the sector. The block XORs them with the freshly computed code and classifies the resulting error vector:
- clean;
- a data bit to flip, given as a byte index and a bit mask;
- a single flipped bit in the stored code itself;
- uncorrectable.

The sector is kept in a local buffer. Reads from that buffer return the byte with the correction applied.

Top module: `nham_ecc_top`

## Requirements
- R1: A one-cycle pulse on `sec_start` clears the parity state, the data and code byte counters and the result. In the cycle after the pulse, `res_valid` and `par_out_valid` are 0. A data byte presented in the same cycle as `sec_start` is not taken.
- R2: The computed code holds the even half in bits 11:0 and the odd half in bits 23:12, and the whole 24-bit value is inverted. Index bit k is byte-address bit k-3 for k of 3 or more, and bit-position bit k for k below 3. An erased sector of 0xFF bytes therefore yields 0xFFFFFF.
- R3: The computed code is emitted least significant byte first, on `par_out_byte` with `par_out_valid` high. The three bytes come on three consecutive cycles, starting with the cycle right after the one in which the 512th data byte was presented.
- R4: Stored code bytes are taken only after all 512 data bytes have arrived, least significant byte first. The result appears in the cycle after the third byte is presented and is held until the next `sec_start`.
- R5: If the computed and stored codes are equal, `res_status` is 0 (clean) and `res_mask` is 0.
- R6: If the upper 12 bits of the error vector XOR its lower 12 bits equal 0xFFF, the error is a data error. `res_status` is 1, `res_byte` is vector bits 23:15, and `res_mask` has the single bit set that vector bits 14:12 select.
- R7: A data error whose byte index is not below the sector size reports `res_status` 3 (uncorrectable).
- R8: An error vector with exactly one bit set reports `res_status` 2 (stored code corrected). `res_mask` is 0 and the buffered data is unchanged.
- R9: Any other nonzero error vector reports `res_status` 3 and `res_mask` 0.
- R10: `rd_data` returns the buffered byte at `rd_addr`. While a status-1 result is held, the byte at `res_byte` is returned XORed with `res_mask`, and no other byte is altered.
- R11: Data bytes presented after the 512th byte of a sector are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_start | input | 1 | Sector start strobe |
| din_valid | input | 1 | Data byte qualifier |
| din | input | 8 | Sector data byte |
| code_valid | input | 1 | Stored code byte qualifier |
| code_byte | input | 8 | Stored code byte, LSB first |
| par_out_valid | output | 1 | Computed code byte valid |
| par_out_byte | output | 8 | Computed code byte, LSB first |
| rd_addr | input | 9 | Buffer read address |
| rd_data | output | 8 | Buffer byte with correction applied |
| res_valid | output | 1 | Classification result valid |
| res_status | output | 2 | 0 clean, 1 data fixed, 2 code fixed, 3 uncorrectable |
| res_byte | output | 9 | Byte index of the data error |
| res_mask | output | 8 | Bit mask to flip at `res_byte` |

## Verification
The checker is fed several kinds of sector:
- an erased sector, which pins down the inversion;
- an arithmetic byte pattern checked clean, which ties every index bit to its own parity half;
- single flipped data bits at the first byte bit 0, the last byte bit 7 and a middle byte, which separate the byte-index and bit-position fields from each other;
- a stored code with one flipped bit, which must not touch the data;
- two flipped data bits, which must be reported uncorrectable.

A second instance with a 300-byte sector takes crafted stored codes, so that an index beyond the sector is told apart from an in-range one. Further sectors carry a byte beside the start strobe, a surplus byte and early code bytes, to show that each of them is ignored.

// File: rtl/nham_pkg.sv
package nham_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_DATA_FIX = 2'd1,
        ST_CODE_FIX = 2'd2,
        ST_UNCORR   = 2'd3
    } nham_status_e;

    localparam int BIT_IDX_W = 3;

    // Parity of the bits of b whose bit position has bit k equal to sel.
    function automatic logic col_par(input logic [7:0] b, input int k, input logic sel);
        logic p;
        logic [2:0] ii;
        p = 1'b0;
        for (int i = 0; i < 8; i++) begin
            ii = 3'(i);
            if (ii[k] == sel) p = p ^ b[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/nham_accum.sv
module nham_accum
    import nham_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_W       = 9,
    parameter int HALF         = ADDR_W + BIT_IDX_W,
    parameter int CNT_W        = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              din_valid,
    input  logic [7:0]        din,
    output logic [HALF-1:0]   even_q,
    output logic [HALF-1:0]   odd_q,
    output logic              full,
    output logic              last_take,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(SECTOR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SECTOR_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [HALF-1:0]  even_n, odd_n;
    logic             take, bpar;

    assign take      = din_valid && !clr && (cnt_q < CNT_END);
    assign full      = (cnt_q == CNT_END);
    assign last_take = take && (cnt_q == CNT_LAST);
    assign wr_en     = take;
    assign wr_addr   = cnt_q[ADDR_W-1:0];
    assign bpar      = ^din;

    always_comb begin
        even_n = even_q;
        odd_n  = odd_q;
        for (int k = 0; k < BIT_IDX_W; k++) begin
            even_n[k] = even_q[k] ^ col_par(din, k, 1'b0);
            odd_n[k]  = odd_q[k]  ^ col_par(din, k, 1'b1);
        end
        for (int j = 0; j < ADDR_W; j++) begin
            if (wr_addr[j]) odd_n[BIT_IDX_W+j]  = odd_q[BIT_IDX_W+j]  ^ bpar;
            else            even_n[BIT_IDX_W+j] = even_q[BIT_IDX_W+j] ^ bpar;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q  <= '0;
            even_q <= '0;
            odd_q  <= '0;
        end else if (take) begin
            cnt_q  <= cnt_q + CNT_W'(1);
            even_q <= even_n;
            odd_q  <= odd_n;
        end
    end
endmodule

// File: rtl/nham_classify.sv
module nham_classify
    import nham_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_W       = 9,
    parameter int HALF         = ADDR_W + BIT_IDX_W,
    parameter int CODE_W       = 2 * HALF
) (
    input  logic [CODE_W-1:0] calc,
    input  logic [CODE_W-1:0] stored,
    output nham_status_e      status,
    output logic [ADDR_W-1:0] byte_idx,
    output logic [7:0]        mask
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SECTOR_BYTES);

    logic [CODE_W-1:0] diff;
    logic [HALF-1:0]   hi, lo;

    assign diff = calc ^ stored;
    assign hi   = diff[CODE_W-1:HALF];
    assign lo   = diff[HALF-1:0];

    always_comb begin
        status   = ST_UNCORR;
        byte_idx = '0;
        mask     = '0;
        if (diff == '0) begin
            status = ST_CLEAN;
        end else if ((hi ^ lo) == {HALF{1'b1}}) begin
            if ({1'b0, hi[HALF-1:BIT_IDX_W]} < CNT_END) begin
                status   = ST_DATA_FIX;
                byte_idx = hi[HALF-1:BIT_IDX_W];
                mask     = 8'b1 << hi[BIT_IDX_W-1:0];
            end
        end else if ($countones(diff) == 1) begin
            status = ST_CODE_FIX;
        end
    end
endmodule

// File: rtl/nham_secbuf.sv
module nham_secbuf #(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_W       = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              fix_en,
    input  logic [ADDR_W-1:0] fix_addr,
    input  logic [7:0]        fix_mask,
    output logic [7:0]        rd_data
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH = CNT_W'(SECTOR_BYTES);

    logic [7:0] mem [SECTOR_BYTES];
    logic [7:0] raw_rd;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        raw_rd = ({1'b0, rd_addr} < DEPTH) ? mem[rd_addr] : 8'h00;
        rd_data = (fix_en && (rd_addr == fix_addr)) ? (raw_rd ^ fix_mask) : raw_rd;
    end
endmodule

// File: rtl/nham_ecc_top.sv
module nham_ecc_top
    import nham_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_W       = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_start,
    input  logic              din_valid,
    input  logic [7:0]        din,
    input  logic              code_valid,
    input  logic [7:0]        code_byte,
    output logic              par_out_valid,
    output logic [7:0]        par_out_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [ADDR_W-1:0] res_byte,
    output logic [7:0]        res_mask
);
    localparam int HALF       = ADDR_W + BIT_IDX_W;
    localparam int CODE_W     = 2 * HALF;
    localparam int CODE_BYTES = (CODE_W + 7) / 8;
    localparam int PAD_W      = CODE_BYTES * 8;
    localparam int EIDX_W     = $clog2(CODE_BYTES);
    localparam int LD_W       = $clog2(CODE_BYTES + 1);
    localparam logic [EIDX_W-1:0] EIDX_LAST = EIDX_W'(CODE_BYTES - 1);
    localparam logic [LD_W-1:0]   LD_END    = LD_W'(CODE_BYTES);
    localparam logic [LD_W-1:0]   LD_LAST   = LD_W'(CODE_BYTES - 1);

    logic [HALF-1:0]   even_q, odd_q;
    logic              full, last_take, wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [CODE_W-1:0] calc_code;
    logic [PAD_W-1:0]  calc_pad;

    nham_accum #(.SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W)) u_accum (
        .clk(clk), .rst(rst), .clr(sec_start),
        .din_valid(din_valid), .din(din),
        .even_q(even_q), .odd_q(odd_q),
        .full(full), .last_take(last_take),
        .wr_en(wr_en), .wr_addr(wr_addr)
    );

    // Odd half above even half, whole word inverted.
    assign calc_code = ~{odd_q, even_q};
    assign calc_pad  = PAD_W'(calc_code);

    // Code emitter for the write path.
    logic              emit_on;
    logic [EIDX_W-1:0] emit_idx;

    always_ff @(posedge clk) begin
        if (rst || sec_start) begin
            emit_on  <= 1'b0;
            emit_idx <= '0;
        end else if (last_take) begin
            emit_on  <= 1'b1;
            emit_idx <= '0;
        end else if (emit_on) begin
            if (emit_idx == EIDX_LAST) emit_on <= 1'b0;
            emit_idx <= emit_idx + EIDX_W'(1);
        end
    end

    assign par_out_valid = emit_on;
    assign par_out_byte  = emit_on ? calc_pad[emit_idx*8 +: 8] : 8'h00;

    // Stored code loader.
    logic [LD_W-1:0]  ld_cnt;
    logic [PAD_W-1:0] stored_q, stored_n;
    logic             ld_take, final_ld;

    assign ld_take  = code_valid && !sec_start && full && (ld_cnt < LD_END) && !res_valid;
    assign final_ld = ld_take && (ld_cnt == LD_LAST);

    always_comb begin
        stored_n = stored_q;
        if (ld_cnt < LD_END) stored_n[ld_cnt*8 +: 8] = code_byte;
    end

    nham_status_e      cls_status;
    logic [ADDR_W-1:0] cls_byte;
    logic [7:0]        cls_mask;

    nham_classify #(.SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W)) u_cls (
        .calc(calc_code), .stored(stored_n[CODE_W-1:0]),
        .status(cls_status), .byte_idx(cls_byte), .mask(cls_mask)
    );

    nham_status_e res_status_q;

    always_ff @(posedge clk) begin
        if (rst || sec_start) begin
            ld_cnt       <= '0;
            stored_q     <= '0;
            res_valid    <= 1'b0;
            res_status_q <= ST_CLEAN;
            res_byte     <= '0;
            res_mask     <= '0;
        end else if (ld_take) begin
            ld_cnt   <= ld_cnt + LD_W'(1);
            stored_q <= stored_n;
            if (final_ld) begin
                res_valid    <= 1'b1;
                res_status_q <= cls_status;
                res_byte     <= cls_byte;
                res_mask     <= cls_mask;
            end
        end
    end

    assign res_status = res_status_q;

    nham_secbuf #(.SECTOR_BYTES(SECTOR_BYTES), .ADDR_W(ADDR_W)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(din),
        .rd_addr(rd_addr),
        .fix_en(res_valid && (res_status_q == ST_DATA_FIX)),
        .fix_addr(res_byte), .fix_mask(res_mask),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/nham_ecc_sva.sv
module nham_ecc_sva (
    input logic       clk,
    input logic       rst,
    input logic       sec_start,
    input logic       code_valid,
    input logic       par_out_valid,
    input logic       res_valid,
    input logic [1:0] res_status,
    input logic [7:0] res_mask
);
    assert_clear_on_start_R1: assert property (@(posedge clk) disable iff (rst)
        sec_start |=> (!res_valid && !par_out_valid));

    assert_emit_run_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(par_out_valid) |=> par_out_valid);

    assert_result_after_load_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> $past(code_valid));

    assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !sec_start) |=> (res_valid && $stable(res_status) && $stable(res_mask)));

    assert_fix_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_status == 2'd1) |-> ($countones(res_mask) == 1));

    assert_no_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_status != 2'd1) |-> (res_mask == 8'd0));
endmodule

bind nham_ecc_top nham_ecc_sva sva_i (
    .clk(clk), .rst(rst), .sec_start(sec_start), .code_valid(code_valid),
    .par_out_valid(par_out_valid), .res_valid(res_valid),
    .res_status(res_status), .res_mask(res_mask)
);

// File: tb/nham_ecc_top_tb_top.sv
module nham_ecc_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // Full-size instance.
    logic       sec_start = 0, din_valid = 0, code_valid = 0;
    logic [7:0] din = 0, code_byte = 0;
    logic [8:0] rd_addr = 0;
    logic       par_out_valid, res_valid;
    logic [7:0] par_out_byte, rd_data, res_mask;
    logic [1:0] res_status;
    logic [8:0] res_byte;

    nham_ecc_top dut_i (
        .clk(clk), .rst(rst), .sec_start(sec_start), .din_valid(din_valid), .din(din),
        .code_valid(code_valid), .code_byte(code_byte),
        .par_out_valid(par_out_valid), .par_out_byte(par_out_byte),
        .rd_addr(rd_addr), .rd_data(rd_data), .res_valid(res_valid),
        .res_status(res_status), .res_byte(res_byte), .res_mask(res_mask)
    );

    // Short-sector instance, 300 bytes, 9-bit index.
    logic       s_start = 0, s_dv = 0, s_cv = 0;
    logic [7:0] s_din = 0, s_cb = 0;
    logic [8:0] s_rd_addr = 0;
    logic       s_pov, s_rv;
    logic [7:0] s_pob, s_rd, s_mask;
    logic [1:0] s_status;
    logic [8:0] s_byte;

    nham_ecc_top #(.SECTOR_BYTES(300)) dut_s (
        .clk(clk), .rst(rst), .sec_start(s_start), .din_valid(s_dv), .din(s_din),
        .code_valid(s_cv), .code_byte(s_cb),
        .par_out_valid(s_pov), .par_out_byte(s_pob),
        .rd_addr(s_rd_addr), .rd_data(s_rd), .res_valid(s_rv),
        .res_status(s_status), .res_byte(s_byte), .res_mask(s_mask)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] sect [512];
    logic [7:0] good [512];

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model_code(input int n);
        logic [11:0] ev, od, idx;
        ev = '0; od = '0;
        for (int a = 0; a < n; a++)
            for (int i = 0; i < 8; i++)
                if (sect[a][i]) begin
                    idx = 12'(a * 8 + i);
                    for (int k = 0; k < 12; k++)
                        if (idx[k]) od[k] = ~od[k]; else ev[k] = ~ev[k];
                end
        return ~{od, ev};
    endfunction

    task automatic fill_pattern(input int seed);
        for (int a = 0; a < 512; a++) begin
            sect[a] = 8'((a * 37 + seed) ^ (a >> 3));
            good[a] = sect[a];
        end
    endtask

    task automatic start_sector();
        sec_start = 1; @(negedge clk); sec_start = 0;
    endtask

    // Streams sect[0..511] and checks the emitted code (R3).
    task automatic send_sector();
        logic [23:0] exp;
        exp = model_code(512);
        for (int a = 0; a < 512; a++) begin
            din = sect[a]; din_valid = 1; @(negedge clk);
        end
        din_valid = 0;
        for (int b = 0; b < 3; b++) begin
            chk(par_out_valid && par_out_byte == exp[8*b +: 8], "R3 code byte",
                int'({par_out_valid, par_out_byte}), int'({1'b1, exp[8*b +: 8]}));
            @(negedge clk);
        end
        chk(!par_out_valid, "R3 emit end", int'(par_out_valid), 0);
    endtask

    task automatic load_code(input logic [23:0] c);
        for (int b = 0; b < 3; b++) begin
            chk(!res_valid, "R4 no early result", int'(res_valid), 0);
            code_byte = c[8*b +: 8]; code_valid = 1; @(negedge clk);
        end
        code_valid = 0;
    endtask

    task automatic check_res(input logic [1:0] st, input logic [8:0] bi,
                             input logic [7:0] m, input string req);
        chk(res_valid, {req, " valid"}, int'(res_valid), 1);
        chk(res_status == st, {req, " status"}, int'(res_status), int'(st));
        if (st == 2'd1) chk(res_byte == bi, {req, " byte"}, int'(res_byte), int'(bi));
        chk(res_mask == m, {req, " mask"}, int'(res_mask), int'(m));
    endtask

    task automatic rd_chk(input int a, input logic [7:0] e, input string req);
        rd_addr = 9'(a); #1;
        chk(rd_data == e, req, int'(rd_data), int'(e));
    endtask

    task automatic t_reset();
        chk(!res_valid, "R1 reset result", int'(res_valid), 0);
        chk(!par_out_valid, "R1 reset emit", int'(par_out_valid), 0);
    endtask

    task automatic t_erased();
        for (int a = 0; a < 512; a++) sect[a] = 8'hFF;
        chk(model_code(512) == 24'hFFFFFF, "R2 erased model", int'(model_code(512)), 32'hFFFFFF);
        start_sector(); send_sector();
        load_code(24'hFFFFFF);
        check_res(2'd0, 9'd0, 8'd0, "R5 erased clean");
    endtask

    task automatic t_clean();
        fill_pattern(11);
        start_sector(); send_sector();
        load_code(model_code(512));
        check_res(2'd0, 9'd0, 8'd0, "R5 pattern clean");
    endtask

    task automatic t_data_fix(input int a, input int bt);
        logic [23:0] c;
        fill_pattern(a + bt);
        c = model_code(512);
        sect[a] = sect[a] ^ (8'b1 << bt);
        start_sector(); send_sector();
        load_code(c);
        check_res(2'd1, 9'(a), 8'b1 << bt, "R6 data fix");
        rd_chk(a, good[a], "R10 fixed byte");
        rd_chk((a + 1) % 512, good[(a + 1) % 512], "R10 neighbour byte");
    endtask

    task automatic t_code_fix();
        logic [23:0] c;
        fill_pattern(77);
        c = model_code(512) ^ 24'h002000;
        start_sector(); send_sector();
        load_code(c);
        check_res(2'd2, 9'd0, 8'd0, "R8 code fix");
        rd_chk(5, good[5], "R8 data untouched");
        repeat (3) @(negedge clk);
        check_res(2'd2, 9'd0, 8'd0, "R4 result held");
    endtask

    task automatic t_double();
        logic [23:0] c;
        fill_pattern(5);
        c = model_code(512);
        sect[10] = sect[10] ^ 8'h04;
        sect[300] = sect[300] ^ 8'h40;
        start_sector(); send_sector();
        load_code(c);
        check_res(2'd3, 9'd0, 8'd0, "R9 double error");
    endtask

    task automatic t_ignore();
        fill_pattern(123);
        // Byte beside the start strobe must not be taken (R1).
        sec_start = 1; din_valid = 1; din = 8'h5A; @(negedge clk);
        sec_start = 0; din_valid = 0;
        // Early code bytes ignored (R4).
        for (int b = 0; b < 3; b++) begin
            code_byte = 8'h00; code_valid = 1; @(negedge clk);
        end
        code_valid = 0;
        chk(!res_valid, "R4 early code ignored", int'(res_valid), 0);
        send_sector();
        // Surplus byte (R11).
        din = 8'h81; din_valid = 1; @(negedge clk); din_valid = 0;
        chk(!par_out_valid, "R11 no re-emit", int'(par_out_valid), 0);
        load_code(model_code(512));
        check_res(2'd0, 9'd0, 8'd0, "R1 R11 sector intact");
        rd_chk(0, good[0], "R1 first byte stored");
        start_sector();
        chk(!res_valid, "R1 result cleared", int'(res_valid), 0);
    endtask

    task automatic t_short(input int byte_i, input logic [1:0] st);
        logic [23:0] c;
        logic [11:0] idx;
        fill_pattern(9);
        idx = {9'(byte_i), 3'd2};
        c = model_code(300) ^ {idx, ~idx};
        s_start = 1; @(negedge clk); s_start = 0;
        for (int a = 0; a < 300; a++) begin
            s_din = sect[a]; s_dv = 1; @(negedge clk);
        end
        s_dv = 0;
        repeat (3) @(negedge clk);
        for (int b = 0; b < 3; b++) begin
            s_cb = c[8*b +: 8]; s_cv = 1; @(negedge clk);
        end
        s_cv = 0;
        chk(s_rv, "R7 short valid", int'(s_rv), 1);
        chk(s_status == st, "R7 short status", int'(s_status), int'(st));
        if (st == 2'd1) chk(s_byte == 9'(byte_i), "R7 short byte", int'(s_byte), byte_i);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_erased();
        t_clean();
        t_data_fix(0, 0);
        t_data_fix(511, 7);
        t_data_fix(200, 3);
        t_code_fix();
        t_double();
        t_ignore();
        t_short(400, 2'd3);
        t_short(100, 2'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule